// File: doc/BRIEF.md
# Register Mailbox Memory Writer with Running CRC

This block sits behind a management register port and turns a sequence of 16-bit register writes into 32-bit writes on a memory port. Software loads a 32-bit target address as two halves, stages a 32-bit data word as two halves, and then issues a command that commits the staged word to memory at the current address. After every commit the address moves on by one word, so a stream of words lands in consecutive locations without reloading the address.

Alongside the writes the block keeps a running 16-bit CRC (polynomial 0x1021, MSB-first, no final XOR) over every committed word, fed most significant byte first. Software clears the CRC before a section, streams the section in, and reads the CRC back to compare it with its own. The CRC is folded in over a fixed number of cycles after each commit; a busy flag, visible in the command register, blocks further commands until the update is complete.

Top module: `mbox_mem_writer`

## Requirements
- R1: After reset the address pointer, both staged data halves and the CRC read 0, the busy flag (command register bit 15) reads 0 and the memory write strobe is low.
- R2: A write to offset 2 sets address bits 31:16 and a write to offset 3 sets address bits 15:0 with bits 1:0 forced to 0; both offsets read back the current pointer halves, and every memory write uses an address with bits 1:0 equal to 0.
- R3: A write to offset 4 stages data bits 31:16 and a write to offset 5 stages data bits 15:0; both offsets read back the staged halves.
- R4: A write to offset 0 with bit 1 (execute) and bit 2 (write) both set, while not busy, raises the memory write strobe for exactly one cycle, starting the cycle after the command, carrying the pointer and the staged word; execute without the write bit produces no memory write.
- R5: Each committed write advances the pointer by 4, modulo 2^32, visible at offsets 2 and 3 the cycle after the command.
- R6: Each committed word updates the CRC (polynomial 0x1021, MSB-first) over bytes 31:24, 23:16, 15:8, 7:0 in that order, starting from the current CRC; the result reads at offset 1 once busy is low, and the CRC does not change while idle without a clear.
- R7: After a commit the busy flag reads 1 for exactly 4 cycles (32 / 8 bits per step) and then 0; any write to offset 0 while busy is ignored entirely.
- R8: Command bit 0 sets the CRC to 0 without changing the pointer or staged data; when given together with a commit, the clear applies first and the CRC covers only that word.
- R9: Offsets 6 and 7 read 0, and writes to offsets 1, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe, one write per cycle high |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 1 | Memory write strobe |

## Verification
A register write takes effect at the rising edge that samples the strobe, so the bench reads it back at the following falling edge through the combinational read port. The memory strobe, address and data are registered and therefore due at the falling edge right after the commit edge, which is where the bench samples them; the pointer readback is due at that same point. The busy flag is sampled at each of the next falling edges to confirm four high cycles, and the CRC is compared only after busy has dropped, against a byte-wise reference computed in the bench.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  typedef enum logic [2:0] {
    SEL_CMD  = 3'd0,
    SEL_CRC  = 3'd1,
    SEL_ADRH = 3'd2,
    SEL_ADRL = 3'd3,
    SEL_DATH = 3'd4,
    SEL_DATL = 3'd5
  } reg_sel_e;

  localparam int CMD_CLR_BIT  = 0;
  localparam int CMD_EXE_BIT  = 1;
  localparam int CMD_WR_BIT   = 2;
  localparam int CRC_W        = 16;
  localparam int MAX_STEP_W   = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  // Fold the top n bits of 'bits' into the CRC, MSB first.
  function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] crc_in,
                                                input logic [MAX_STEP_W-1:0] bits,
                                                input int n);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc_in;
    for (int i = 0; i < MAX_STEP_W; i++) begin
      if (i < n) begin
        fb = c[CRC_W-1] ^ bits[MAX_STEP_W-1-i];
        c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
      end
    end
    return c;
  endfunction

endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int SEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     reg_sel,
  input  logic [REG_W-1:0]     reg_wdata,
  input  logic                 reg_we,
  input  logic                 busy,
  output logic [2*REG_W-1:0]   ptr,
  output logic [2*REG_W-1:0]   staged,
  output logic                 commit_evt,
  output logic                 crc_clr_evt
);
  localparam int WORD_W     = 2 * REG_W;
  localparam int BYTE_STEP  = WORD_W / 8;
  localparam int ALIGN_BITS = $clog2(BYTE_STEP);

  logic cmd_accept;
  logic wr_adrh, wr_adrl;

  assign cmd_accept  = reg_we && (reg_sel == SEL_W'(SEL_CMD)) && !busy;
  assign commit_evt  = cmd_accept && reg_wdata[CMD_EXE_BIT] && reg_wdata[CMD_WR_BIT];
  assign crc_clr_evt = cmd_accept && reg_wdata[CMD_CLR_BIT];
  assign wr_adrh     = reg_we && (reg_sel == SEL_W'(SEL_ADRH));
  assign wr_adrl     = reg_we && (reg_sel == SEL_W'(SEL_ADRL));

  // Address pointer: loaded in halves, advanced by one word per commit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (commit_evt) begin
      ptr <= ptr + WORD_W'(BYTE_STEP);
    end else if (wr_adrh) begin
      ptr[WORD_W-1:REG_W] <= reg_wdata;
    end else if (wr_adrl) begin
      ptr[REG_W-1:0] <= {reg_wdata[REG_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
  end

  // Staged data halves: half 1 is the upper half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [SEL_W-1:0] HALF_SEL = (h == 1) ? SEL_W'(SEL_DATH) : SEL_W'(SEL_DATL);
    logic [REG_W-1:0] half_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        half_q <= '0;
      else if (reg_we && (reg_sel == HALF_SEL))
        half_q <= reg_wdata;
    end
    assign staged[h*REG_W +: REG_W] = half_q;
  end

endmodule

// File: rtl/mbox_crc_engine.sv
module mbox_crc_engine
  import mbox_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int STEP_BITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clear,
  input  logic [WORD_W-1:0] word,
  output logic [CRC_W-1:0]  crc,
  output logic              busy,
  output logic              step_evt
);
  localparam int NSTEP = WORD_W / STEP_BITS;
  localparam int CNT_W = $clog2(NSTEP + 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MAX_STEP_W-1:0] step_bits;

  assign busy     = (cnt_q != '0);
  assign step_evt = busy;
  assign step_bits = MAX_STEP_W'(sh_q[WORD_W-1 -: STEP_BITS]) << (MAX_STEP_W - STEP_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
    end else if (clear) begin
      crc <= '0;
    end else if (step_evt) begin
      crc <= crc_fold(crc, step_bits, STEP_BITS);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sh_q  <= word;
      cnt_q <= CNT_W'(NSTEP);
    end else if (step_evt) begin
      sh_q  <= sh_q << STEP_BITS;
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/mbox_mem_port.sv
module mbox_mem_port #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [WORD_W-1:0] ptr,
  input  logic [WORD_W-1:0] staged,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= commit;
      if (commit) begin
        mem_addr  <= ptr;
        mem_wdata <= staged;
      end
    end
  end
endmodule

// File: rtl/mbox_mem_writer.sv
module mbox_mem_writer
  import mbox_pkg::*;
#(
  parameter int REG_W     = 16,
  parameter int SEL_W     = 3,
  parameter int STEP_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SEL_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  input  logic               reg_we,
  output logic [REG_W-1:0]   reg_rdata,
  output logic [2*REG_W-1:0] mem_addr,
  output logic [2*REG_W-1:0] mem_wdata,
  output logic               mem_we
);
  localparam int WORD_W = 2 * REG_W;

  logic [WORD_W-1:0] ptr;
  logic [WORD_W-1:0] staged;
  logic              commit_evt;
  logic              crc_clr_evt;
  logic              busy;
  logic              step_evt;
  logic [CRC_W-1:0]  crc_val;

  mbox_regs #(.REG_W(REG_W), .SEL_W(SEL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_sel     (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_we      (reg_we),
    .busy        (busy),
    .ptr         (ptr),
    .staged      (staged),
    .commit_evt  (commit_evt),
    .crc_clr_evt (crc_clr_evt)
  );

  mbox_crc_engine #(.WORD_W(WORD_W), .STEP_BITS(STEP_BITS)) u_crc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (commit_evt),
    .clear    (crc_clr_evt),
    .word     (staged),
    .crc      (crc_val),
    .busy     (busy),
    .step_evt (step_evt)
  );

  mbox_mem_port #(.WORD_W(WORD_W)) u_mem (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (commit_evt),
    .ptr       (ptr),
    .staged    (staged),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      SEL_W'(SEL_CMD):  reg_rdata[REG_W-1] = busy;
      SEL_W'(SEL_CRC):  reg_rdata = REG_W'(crc_val);
      SEL_W'(SEL_ADRH): reg_rdata = ptr[WORD_W-1:REG_W];
      SEL_W'(SEL_ADRL): reg_rdata = ptr[REG_W-1:0];
      SEL_W'(SEL_DATH): reg_rdata = staged[WORD_W-1:REG_W];
      SEL_W'(SEL_DATL): reg_rdata = staged[REG_W-1:0];
      default:          reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_evt,
  input logic              crc_clr_evt,
  input logic              busy,
  input logic [15:0]       crc_val,
  input logic [WORD_W-1:0] ptr,
  input logic [WORD_W-1:0] mem_addr,
  input logic              mem_we
);
  AST_COMMIT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> mem_we);  // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);  // R4
  AST_COMMIT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (mem_addr == $past(ptr)));  // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> (ptr == $past(ptr) + WORD_W'(4)));  // R5
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[1:0] == 2'b00));  // R2
  AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> busy);  // R7
  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_evt);  // R7
  AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !crc_clr_evt) |=> $stable(crc_val));  // R6
  AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_clr_evt && !commit_evt) |=> (crc_val == 16'h0000));  // R8
endmodule

bind mbox_mem_writer mbox_checker #(.WORD_W(2*REG_W)) u_mbox_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .commit_evt  (commit_evt),
  .crc_clr_evt (crc_clr_evt),
  .busy        (busy),
  .crc_val     (crc_val),
  .ptr         (ptr),
  .mem_addr    (mem_addr),
  .mem_we      (mem_we)
);

// File: tb/test_mbox_mem_writer.sv
`timescale 1ns/1ps
module test_mbox_mem_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [15:0] reg_rdata;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_we;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mbox_mem_writer i_mbox_mem_writer (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we)
  );

  // Reference CRC: byte at a time, big-endian byte order of the word.
  function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [31:0] w);
    logic [15:0] c;
    logic [7:0] b;
    c = c_in;
    for (int k = 3; k >= 0; k--) begin
      b = w[8*k +: 8];
      c = c ^ {b, 8'h00};
      for (int j = 0; j < 8; j++)
        c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, captured at the next rising edge; returns at the falling edge after.
  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    reg_rd(a, d);
    check(req, {16'h0, d}, {16'h0, exp});
  endtask

  task automatic wait_idle();
    logic [15:0] d;
    for (int i = 0; i < 20; i++) begin
      reg_rd(3'd0, d);
      if (!d[15]) return;
      @(negedge clk);
    end
  endtask

  task automatic load_addr(input logic [31:0] a);
    reg_wr(3'd2, a[31:16]);
    reg_wr(3'd3, a[15:0]);
  endtask

  task automatic load_data(input logic [31:0] w);
    reg_wr(3'd4, w[31:16]);
    reg_wr(3'd5, w[15:0]);
  endtask

  // Commit and check the memory port at the falling edge after the commit edge.
  task automatic commit_chk(input string req, input logic [15:0] cmd,
                            input logic [31:0] exp_a, input logic [31:0] exp_d);
    reg_wr(3'd0, cmd);
    check({req, " strobe"}, {31'h0, mem_we}, 32'h1);
    check({req, " addr"}, mem_addr, exp_a);
    check({req, " data"}, mem_wdata, exp_d);
  endtask

  task automatic t_reset();
    check("R1 strobe", {31'h0, mem_we}, 32'h0);
    for (int a = 0; a < 6; a++) rd_check("R1 reg", 3'(a), 16'h0000);
  endtask

  task automatic t_addr_data();
    load_addr(32'h3FFE_0003);
    rd_check("R2 addr hi", 3'd2, 16'h3FFE);
    rd_check("R2 addr lo aligned", 3'd3, 16'h0000);
    load_data(32'h3132_3334);
    rd_check("R3 data hi", 3'd4, 16'h3132);
    rd_check("R3 data lo", 3'd5, 16'h3334);
  endtask

  task automatic t_clear_and_commit();
    logic [15:0] d;
    // Put some CRC in, then clear it (R8).
    commit_chk("R4 first", 16'h0006, 32'h3FFE_0000, 32'h3132_3334);
    wait_idle();
    rd_check("R6 crc one word", 3'd1, ref_crc(16'h0, 32'h3132_3334));
    reg_wr(3'd0, 16'h0001);
    rd_check("R8 crc cleared", 3'd1, 16'h0000);
    rd_check("R8 addr kept hi", 3'd2, 16'h3FFE);
    rd_check("R8 addr kept lo", 3'd3, 16'h0004);
    rd_check("R8 data kept", 3'd4, 16'h3132);
    // Busy pattern after commit (R7).
    commit_chk("R4 second", 16'h0006, 32'h3FFE_0004, 32'h3132_3334);
    rd_check("R5 ptr lo", 3'd3, 16'h0008);
    for (int i = 0; i < 4; i++) begin
      reg_rd(3'd0, d);
      check("R7 busy high", {31'h0, d[15]}, 32'h1);
      @(negedge clk);
    end
    reg_rd(3'd0, d);
    check("R7 busy low", {31'h0, d[15]}, 32'h0);
    rd_check("R6 crc after clear", 3'd1, ref_crc(16'h0, 32'h3132_3334));
  endtask

  task automatic t_exec_only();
    reg_wr(3'd0, 16'h0002);
    check("R4 exec only no strobe", {31'h0, mem_we}, 32'h0);
    rd_check("R4 exec only ptr", 3'd3, 16'h0008);
  endtask

  task automatic t_busy_block();
    logic [15:0] c0;
    reg_rd(3'd1, c0);
    load_data(32'hDEAD_BEEF);
    commit_chk("R4 busy-test", 16'h0006, 32'h3FFE_0008, 32'hDEAD_BEEF);
    // Immediately issue clear+commit while busy: must be ignored.
    reg_wr(3'd0, 16'h0007);
    check("R7 ignored strobe", {31'h0, mem_we}, 32'h0);
    rd_check("R7 ignored ptr", 3'd3, 16'h000C);
    wait_idle();
    rd_check("R7 ignored crc", 3'd1, ref_crc(c0, 32'hDEAD_BEEF));
  endtask

  task automatic t_clear_with_commit();
    load_data(32'h0123_4567);
    commit_chk("R8 clr+commit", 16'h0007, 32'h3FFE_000C, 32'h0123_4567);
    wait_idle();
    rd_check("R8 crc covers one word", 3'd1, ref_crc(16'h0, 32'h0123_4567));
  endtask

  task automatic t_stream_wrap();
    logic [15:0] c;
    logic [31:0] w [3];
    w[0] = 32'hFFFF_FFFF; w[1] = 32'h0000_0000; w[2] = 32'h8001_7FFE;
    load_addr(32'hFFFF_FFF8);
    reg_wr(3'd0, 16'h0001);
    c = 16'h0;
    for (int i = 0; i < 3; i++) begin
      load_data(w[i]);
      commit_chk("R5 stream", 16'h0006, 32'hFFFF_FFF8 + 32'(4*i), w[i]);
      wait_idle();
      c = ref_crc(c, w[i]);
      rd_check("R6 chained crc", 3'd1, c);
    end
    rd_check("R5 wrap hi", 3'd2, 16'h0000);
    rd_check("R5 wrap lo", 3'd3, 16'h0004);
  endtask

  task automatic t_unmapped();
    logic [15:0] c0;
    reg_rd(3'd1, c0);
    reg_wr(3'd1, 16'h5A5A);
    reg_wr(3'd6, 16'hFFFF);
    reg_wr(3'd7, 16'hFFFF);
    check("R9 no strobe", {31'h0, mem_we}, 32'h0);
    rd_check("R9 crc untouched", 3'd1, c0);
    rd_check("R9 off6 zero", 3'd6, 16'h0000);
    rd_check("R9 off7 zero", 3'd7, 16'h0000);
    rd_check("R9 addr untouched", 3'd3, 16'h0004);
    rd_check("R9 data untouched", 3'd5, 16'h7FFE);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_data();
    t_clear_and_commit();
    t_exec_only();
    t_busy_block();
    t_clear_with_commit();
    t_stream_wrap();
    t_unmapped();
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule